// File: doc/BRIEF.md
# Indirect Command and Status Register Port

This block is the host-facing register front end of a network controller. The host cannot address the controller's registers directly. It first writes a register number into a pointer port, then reads or writes the chosen register through a data port. Both ports are 16 bits wide. The data port sits at byte offset 0 and the pointer port at byte offset 2. Input `port_sel_i` carries that distinction: 0 selects the data port and 1 selects the pointer port. Reads are combinational from the current pointer and port select.

Register 0 is the command and status word. It accepts one-shot commands: initialize, start, stop and transmit poll. These leave the block as single-cycle pulses towards the DMA engines. The word also holds the transmitter and receiver run state and an interrupt enable. It gathers seven sticky event flags from the engines. Two summary bits are derived from those flags: an error summary and an interrupt summary. The interrupt output is the interrupt summary gated by the interrupt enable.

Registers 1 and 2 hold the low and high halves of the initialization block address. Register 3 holds three bus-mode bits. Registers 1 to 3 can only be changed while the controller is stopped.

Top module: `netc_csr_port`

## Requirements
- R1: A write to the pointer port stores its low 2 bits as the register number, and a read of the pointer port returns that number zero-extended. Data-port reads and writes reach the register that the pointer selects.
- R2: After reset, register 0 reads 0x0004 (stopped) and registers 1 to 3 read 0. The pointer reads 0, all pulse outputs are low, and the run-state and interrupt outputs are low.
- R3: A data write with bit 2 set stops the controller. On the next cycle `stop_cmd_o` pulses for one cycle, and bits 4 and 5 clear. All flags in bits 8 to 14 clear, and bit 2 reads 1. Stop overrides the start, initialize and poll bits of the same write, so no other pulse is issued.
- R4: A data write with bit 0 set, made while stopped, pulses `init_cmd_o` for one cycle. Bit 0 then reads 1 until the initialization-done event arrives.
- R5: A data write with bit 1 set pulses `start_cmd_o` for one cycle and sets bit 4 (transmit on) and bit 5 (receive on). After it, bit 1 reads 1 and bit 2 reads 0.
- R6: A data write with bit 3 set pulses `tx_poll_o` for one cycle only when the transmitter is on. While stopped, the bit is ignored. Bit 3 always reads 0.
- R7: Event input `evt_i[k]` sets flag bit 8+k and the flag stays set. The order from k=0 is: init done, transmit done, receive done, memory error, missed frame, carrier error, babble. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write wins.
- R8: Bit 15 reads as the OR of bits 11 to 14. Bit 7 reads as the OR of bits 8 to 14. Writes to bits 7 and 15 have no effect.
- R9: Bit 6 (interrupt enable) is written by every register-0 write, and `irq_o` equals bit 7 AND bit 6.
- R10: `init_addr_o` is {register 2, register 1}. Register 3 bits 2:0 drive `bus_mode_o`, and its upper bits read 0. Writes to registers 1 to 3 are ignored unless bit 2 of register 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 1 | 0 selects the data port, 1 the pointer port |
| wr_i | input | 1 | Write strobe for the selected port |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected port |
| evt_i | input | 7 | Event strobes from the engines, one per flag |
| init_cmd_o | output | 1 | Initialize pulse |
| start_cmd_o | output | 1 | Start pulse |
| stop_cmd_o | output | 1 | Stop pulse |
| tx_poll_o | output | 1 | Immediate transmit descriptor poll pulse |
| tx_on_o | output | 1 | Transmitter running |
| rx_on_o | output | 1 | Receiver running |
| irq_o | output | 1 | Interrupt request |
| init_addr_o | output | 32 | Initialization block address |
| bus_mode_o | output | 3 | Bus-mode bits |

## Verification
All four pointer values are swept, with distinct data patterns written through the data port. This separates a misrouted pointer from a register that stores wrongly. Each of the seven events is raised alone and then cleared alone. That separates the flag position, the error-summary membership and the write-one-to-clear mask for every flag. Commands are tried both stopped and running, and combined in one write, which shows whether stop priority and the transmit-on gate of the poll are honoured. A clear that collides with a same-cycle event distinguishes set-wins from clear-wins.

// File: rtl/netc_csr_pkg.sv
package netc_csr_pkg;
  localparam int DATA_W  = 16;
  localparam int NUM_CSR = 4;
  localparam int PTR_W   = $clog2(NUM_CSR);
  localparam int NUM_CFG = NUM_CSR - 1;
  localparam int N_EVT   = 7;
  localparam int MODE_W  = 3;
  localparam int ADDR_W  = 2 * DATA_W;

  // register 0 bit positions (host software decodes these)
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_POLL = 3;
  localparam int B_INEA = 6;
  localparam int B_EVT0 = 8;
  localparam int B_ERR0 = 11;  // first flag feeding the error summary

  localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'((1 << MODE_W) - 1);
endpackage

// File: rtl/netc_csr0_ctl.sv
module netc_csr0_ctl
  import netc_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_EVT-1:0]  evt_i,
  output logic [DATA_W-1:0] csr0_o,
  output logic              stopped_o,
  output logic              tx_on_o,
  output logic              rx_on_o,
  output logic              irq_o,
  output logic              init_cmd_o,
  output logic              start_cmd_o,
  output logic              stop_cmd_o,
  output logic              tx_poll_o
);
  localparam int ERR_LO = B_ERR0 - B_EVT0;

  logic stopped_q, busy_q, txon_q, rxon_q, inea_q;
  logic init_q, start_q, stop_q, poll_q;
  logic [N_EVT-1:0] flags_q;
  logic do_stop, do_init, do_start, do_poll;
  logic intr, err;

  assign do_stop  = wr_i & wdata_i[B_STOP];
  assign do_init  = wr_i & wdata_i[B_INIT] & stopped_q & ~do_stop;
  assign do_start = wr_i & wdata_i[B_STRT] & ~do_stop;
  assign do_poll  = wr_i & wdata_i[B_POLL] & txon_q & ~do_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stopped_q <= 1'b1;
      busy_q    <= 1'b0;
      txon_q    <= 1'b0;
      rxon_q    <= 1'b0;
      inea_q    <= 1'b0;
      init_q    <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
      poll_q    <= 1'b0;
    end else begin
      init_q  <= do_init;
      start_q <= do_start;
      stop_q  <= do_stop;
      poll_q  <= do_poll;
      if (wr_i) inea_q <= wdata_i[B_INEA];
      if (do_stop) begin
        stopped_q <= 1'b1;
        txon_q    <= 1'b0;
        rxon_q    <= 1'b0;
        busy_q    <= 1'b0;
      end else begin
        if (do_start) begin
          stopped_q <= 1'b0;
          txon_q    <= 1'b1;
          rxon_q    <= 1'b1;
        end
        if (do_init)       busy_q <= 1'b1;
        else if (evt_i[0]) busy_q <= 1'b0;
      end
    end
  end

  // sticky flags: event set beats write-one-to-clear; stop clears all
  for (genvar k = 0; k < N_EVT; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             flags_q[k] <= 1'b0;
      else if (do_stop)                        flags_q[k] <= 1'b0;
      else if (evt_i[k])                       flags_q[k] <= 1'b1;
      else if (wr_i && wdata_i[B_EVT0 + k])    flags_q[k] <= 1'b0;
    end
  end

  assign intr = |flags_q;
  assign err  = |flags_q[N_EVT-1:ERR_LO];

  assign csr0_o = {err, flags_q, intr, inea_q, rxon_q, txon_q,
                   1'b0, stopped_q, ~stopped_q, busy_q};
  assign stopped_o   = stopped_q;
  assign tx_on_o     = txon_q;
  assign rx_on_o     = rxon_q;
  assign irq_o       = intr & inea_q;
  assign init_cmd_o  = init_q;
  assign start_cmd_o = start_q;
  assign stop_cmd_o  = stop_q;
  assign tx_poll_o   = poll_q;

  assert_stop_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_stop |=> (stopped_q && !txon_q && !rxon_q && flags_q == '0 && !start_cmd_o));
  assert_init_when_stopped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_cmd_o) |-> $past(stopped_q));
  assert_poll_needs_tx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_poll_o |-> txon_q);
  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[1] && !do_stop) |=> flags_q[1]);
  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> inea_q);
endmodule

// File: rtl/netc_cfg_regs.sv
module netc_cfg_regs
  import netc_csr_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [PTR_W-1:0]               idx_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           stopped_i,
  output logic [NUM_CFG-1:0][DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = (g == NUM_CFG - 1) ? MODE_MASK : '1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[g] <= '0;
      else if (wr_i && stopped_i && idx_i == PTR_W'(g)) cfg_q[g] <= wdata_i & MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_CFG; g++)
      if (idx_i == PTR_W'(g)) rdata_o = cfg_q[g];
  end

  assign cfg_o = cfg_q;

  assert_cfg_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stopped_i |=> $stable(cfg_q));
endmodule

// File: rtl/netc_csr_port.sv
module netc_csr_port
  import netc_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_sel_i,
  input  logic              wr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic [6:0]        evt_i,
  output logic              init_cmd_o,
  output logic              start_cmd_o,
  output logic              stop_cmd_o,
  output logic              tx_poll_o,
  output logic              tx_on_o,
  output logic              rx_on_o,
  output logic              irq_o,
  output logic [31:0]       init_addr_o,
  output logic [2:0]        bus_mode_o
);
  logic [PTR_W-1:0]               ptr_q;
  logic [PTR_W-1:0]               cfg_idx;
  logic                           data_wr, csr0_wr, cfg_wr, stopped;
  logic [DATA_W-1:0]              csr0, cfg_rdata;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ptr_q <= '0;
    else if (wr_i && port_sel_i)  ptr_q <= wdata_i[PTR_W-1:0];
  end

  assign data_wr = wr_i & ~port_sel_i;
  assign csr0_wr = data_wr & (ptr_q == '0);
  assign cfg_wr  = data_wr & (ptr_q != '0);
  assign cfg_idx = ptr_q - PTR_W'(1);

  netc_csr0_ctl u_csr0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (csr0_wr),
    .wdata_i     (wdata_i),
    .evt_i       (evt_i),
    .csr0_o      (csr0),
    .stopped_o   (stopped),
    .tx_on_o     (tx_on_o),
    .rx_on_o     (rx_on_o),
    .irq_o       (irq_o),
    .init_cmd_o  (init_cmd_o),
    .start_cmd_o (start_cmd_o),
    .stop_cmd_o  (stop_cmd_o),
    .tx_poll_o   (tx_poll_o)
  );

  netc_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr),
    .idx_i     (cfg_idx),
    .wdata_i   (wdata_i),
    .stopped_i (stopped),
    .cfg_o     (cfg),
    .rdata_o   (cfg_rdata)
  );

  always_comb begin
    if (port_sel_i)        rdata_o = DATA_W'(ptr_q);
    else if (ptr_q == '0)  rdata_o = csr0;
    else                   rdata_o = cfg_rdata;
  end

  assign init_addr_o = {cfg[1], cfg[0]};
  assign bus_mode_o  = cfg[NUM_CFG-1][MODE_W-1:0];

  assert_ptr_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && port_sel_i) |=> (ptr_q == $past(wdata_i[PTR_W-1:0])));
  assert_stop_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_cmd_o |-> (!tx_on_o && !rx_on_o && !irq_o));
endmodule

// File: tb/netc_csr_port_tb_top.sv
module netc_csr_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_sel = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [6:0]  evt = '0;
  logic [15:0] rdata;
  logic        init_cmd, start_cmd, stop_cmd, tx_poll, tx_on, rx_on, irq;
  logic [31:0] init_addr;
  logic [2:0]  bus_mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  netc_csr_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_sel_i(port_sel), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
    .init_cmd_o(init_cmd), .start_cmd_o(start_cmd), .stop_cmd_o(stop_cmd),
    .tx_poll_o(tx_poll), .tx_on_o(tx_on), .rx_on_o(rx_on), .irq_o(irq),
    .init_addr_o(init_addr), .bus_mode_o(bus_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // register-0 image from the requirement bit map
  function automatic logic [15:0] img(input logic [6:0] fl, input logic inea,
                                      input logic run, input logic busy);
    logic [15:0] v;
    v = '0;
    v[0] = busy;  v[1] = run;  v[2] = ~run;
    v[4] = run;   v[5] = run;  v[6] = inea;
    v[7] = |fl;   v[14:8] = fl; v[15] = |fl[6:3];
    return v;
  endfunction

  // write takes effect on the next edge; return at the negedge after it
  task automatic wrp(input logic sel, input logic [15:0] d);
    @(negedge clk); port_sel = sel; wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rdp(input logic sel, output logic [15:0] d);
    @(negedge clk); port_sel = sel; #1 d = rdata;
  endtask

  task automatic pulse_evt(input logic [6:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic [15:0] cfgv [3];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rdp(1'b0, r); chk("R2 csr0", r, 16'h0004);
    rdp(1'b1, r); chk("R2 ptr", r, 0);
    chk("R2 outputs", {init_cmd, start_cmd, stop_cmd, tx_poll, tx_on, rx_on, irq}, 0);
    chk("R2 cfg", {init_addr, 29'b0, bus_mode}, 0);

    // R1 pointer sweep, R10 configuration registers while stopped
    for (int k = 0; k < 4; k++) begin
      wrp(1'b1, 16'hFFF0 | 16'(k));
      rdp(1'b1, r); chk("R1 ptr readback", r, 32'(k));
    end
    for (int k = 1; k < 4; k++) begin
      wrp(1'b1, 16'(k));
      cfgv[k-1] = 16'h1357 * 16'(k) ^ 16'hA5A5;
      wrp(1'b0, cfgv[k-1]);
      if (k == 3) cfgv[2] = cfgv[2] & 16'h0007;
    end
    for (int k = 1; k < 4; k++) begin
      wrp(1'b1, 16'(k));
      rdp(1'b0, r); chk("R1 data via ptr", r, cfgv[k-1]);
    end
    chk("R10 init_addr", init_addr, {cfgv[1], cfgv[0]});
    chk("R10 bus_mode", bus_mode, cfgv[2][2:0]);

    // R4 init while stopped
    wrp(1'b1, 16'h0);
    wrp(1'b0, 16'h0001);
    chk("R4 init pulse", {init_cmd, start_cmd, stop_cmd}, 3'b100);
    rdp(1'b0, r); chk("R4 busy", r, img(7'h00, 1'b0, 1'b0, 1'b1));
    chk("R4 pulse one cycle", init_cmd, 0);
    pulse_evt(7'h01);
    rdp(1'b0, r); chk("R4 R7 R8 init done", r, img(7'h01, 1'b0, 1'b0, 1'b0));

    // R7 write zero keeps, write one clears
    wrp(1'b0, 16'h0000);
    rdp(1'b0, r); chk("R7 write zero", r, img(7'h01, 1'b0, 1'b0, 1'b0));
    wrp(1'b0, 16'h0100);
    rdp(1'b0, r); chk("R7 w1c", r, img(7'h00, 1'b0, 1'b0, 1'b0));

    // R6 poll ignored while stopped
    wrp(1'b0, 16'h0008);
    chk("R6 poll stopped", tx_poll, 0);

    // R5 start with interrupt enable
    wrp(1'b0, 16'h0042);
    chk("R5 start pulse", {start_cmd, tx_on, rx_on}, 3'b111);
    rdp(1'b0, r); chk("R5 csr0", r, img(7'h00, 1'b1, 1'b1, 1'b0));

    // R10 locked while running
    wrp(1'b1, 16'h1);
    wrp(1'b0, 16'hFFFF);
    rdp(1'b0, r); chk("R10 locked", r, cfgv[0]);
    wrp(1'b1, 16'h0);

    // R6 poll while running
    wrp(1'b0, 16'h0048);
    chk("R6 poll pulse", tx_poll, 1);
    @(negedge clk); chk("R6 poll one cycle", tx_poll, 0);
    rdp(1'b0, r); chk("R6 bit3 reads 0", r[3], 0);

    // R7 R8 R9 event sweep
    for (int i = 0; i < 7; i++) begin
      pulse_evt(7'(1 << i));
      rdp(1'b0, r); chk("R7 R8 flag set", r, img(7'(1 << i), 1'b1, 1'b1, 1'b0));
      chk("R9 irq", irq, 1);
      wrp(1'b0, 16'(1 << (8 + i)) | 16'h0040);
      rdp(1'b0, r); chk("R7 flag cleared", r, img(7'h00, 1'b1, 1'b1, 1'b0));
      chk("R9 irq low", irq, 0);
    end

    // R9 gate, R8 summary bits not writable
    pulse_evt(7'h02);
    wrp(1'b0, 16'h8080);
    rdp(1'b0, r); chk("R8 summary not writable", r, img(7'h02, 1'b0, 1'b1, 1'b0));
    chk("R9 irq gated", irq, 0);

    // R7 set wins over same-cycle clear
    @(negedge clk); port_sel = 1'b0; wr = 1'b1; wdata = 16'h0200; evt = 7'h02;
    @(negedge clk); wr = 1'b0; wdata = '0; evt = '0;
    rdp(1'b0, r); chk("R7 set wins", r, img(7'h02, 1'b0, 1'b1, 1'b0));

    // R3 stop overrides start and poll
    pulse_evt(7'h40);
    wrp(1'b0, 16'h004E);
    chk("R3 pulses", {stop_cmd, start_cmd, tx_poll, init_cmd}, 4'b1000);
    chk("R3 run off", {tx_on, rx_on}, 0);
    rdp(1'b0, r); chk("R3 csr0", r, img(7'h00, 1'b1, 1'b0, 1'b0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule